// File: doc/BRIEF.md
# AES Decryption Key Preparation Engine

This block takes an AES cipher key held in its key registers and replaces it, in place, with the key that a decryption datapath needs to start from: the last round key of the forward key schedule. It supports 128-bit and 256-bit keys. Software writes the key words, selects the preparation mode and the key width in a control word, and sets the run bit. The block then expands the key one 32-bit word per clock. At a fixed cycle count it writes the result back into the key registers, raises a done flag and drops the run bit by itself.

The preparation runs only in the preparation mode. In the decrypt-only mode the run bit can be set without recomputing anything, so a key prepared once can be reused for many blocks. A chaining-select field is stored but has no effect on the preparation. Initialization-vector writes are dropped while the preparation mode is selected.

Top module: `aes_dec_key_prep`

## Requirements
- R1: After reset the control/status word (address 0) reads 0, and every key word and vector word reads 0.
- R2: A write to address 0 with bit 0 (run) = 1 and bits [2:1] (mode) = 01 starts a preparation. With bit 3 (wide) = 0 the done flag (bit 8 of address 0) reads 1 and run reads 0 exactly 59 cycles after the clock edge that took the write. Run stays 1 and done stays 0 before that cycle.
- R3: With wide = 1 the same flag rise and run drop happen exactly 82 cycles after the starting edge.
- R4: For a 128-bit key, key words 3..0 (addresses 5..2) receive the last round key, word 3 being the most significant 32 bits. Key words 7..4 are left unchanged.
- R5: For a 256-bit key, key words 7..0 (addresses 9..2) receive the last eight schedule words, word 7 the earliest. Words 3..0 therefore hold the last round key, most significant first.
- R6: While run is 1, key reads return the key that was written before the start, and key writes are ignored.
- R7: The chaining field (bits [6:4] of address 0) is stored and read back but does not change the prepared key.
- R8: Writes to the vector words (addresses 10..13) are ignored while the stored mode is 01. In any other mode they are stored.
- R9: With mode 10 and run = 1 no preparation takes place. Run stays 1, the flag stays 0 and the key words keep their values.
- R10: Writing 1 to bit 0 of address 1 clears the done flag, and writing 0 there leaves it set. A later start prepares a new key from whatever the key words then hold.
- R11: While a preparation is running, writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
A wrong schedule word, S-box entry or round constant changes every later schedule word, so it shows up in the key words as soon as the flag rises. The bench reads the key back and compares it with a model and with the published final round keys for both widths. A cycle counter that is off by one moves the flag rise and the run drop by a clock. The control word is compared on every clock of each run, so that error shows at the exact cycle. A broken write guard shows as a changed control word within one clock, or as a wrong prepared key at the flag.

// File: rtl/kd_pkg.sv
package kd_pkg;

   localparam int WORD_W   = 32;
   localparam int NK_MAX   = 8;
   localparam int KEY_BITS = WORD_W * NK_MAX;
   localparam int IV_WORDS = 4;

   typedef enum logic [1:0] {
      OP_ENCRYPT = 2'b00,
      OP_PREPARE = 2'b01,
      OP_DECRYPT = 2'b10,
      OP_RESV    = 2'b11
   } op_mode_e;

   // bit 0 run, bits 2:1 mode, bit 3 wide, bits 6:4 chaining select
   typedef struct packed {
      logic [2:0] chain;
      logic       wide;
      op_mode_e   mode;
      logic       run;
   } ctrl_t;

   function automatic logic [7:0] gf_xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p;
      logic [7:0] x;
      p = 8'h00;
      x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ x;
         x = gf_xtime(x);
      end
      return p;
   endfunction

   // a^254 by square-and-multiply; maps 0 to 0
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] acc;
      acc = a;
      for (int i = 0; i < 6; i++) acc = gf_mul(gf_mul(acc, acc), a);
      return gf_mul(acc, acc);
   endfunction

   function automatic logic [7:0] sbox_byte(input logic [7:0] a);
      logic [7:0] v;
      v = gf_inv(a);
      return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
               ^ {v[3:0], v[7:4]} ^ 8'h63;
   endfunction

endpackage

// File: rtl/kd_subword.sv
module kd_subword #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0] word_i,
   output logic [8*LANES-1:0] word_o
);
   import kd_pkg::*;

   if (LANES < 1) begin : g_bad_lanes
      $error("kd_subword: LANES must be at least 1");
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign word_o[8*b +: 8] = sbox_byte(word_i[8*b +: 8]);
   end

endmodule

// File: rtl/kd_expand.sv
module kd_expand #(
   parameter int LAT_N = 59,
   parameter int LAT_W = 82
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic                        wide_i,
   input  logic [kd_pkg::KEY_BITS-1:0] key_i,
   output logic                        done_o,
   output logic [kd_pkg::KEY_BITS-1:0] key_o
);
   import kd_pkg::*;

   localparam int WORDS_N = 4 * 11 - 4;
   localparam int WORDS_W = 4 * 15 - 8;
   localparam int LAT_MAX = (LAT_W > LAT_N) ? LAT_W : LAT_N;
   localparam int CNT_W   = $clog2(LAT_MAX + 1);
   localparam int LEFT_W  = $clog2(WORDS_W + 1);
   localparam logic [CNT_W-1:0]  LIM_N  = CNT_W'(LAT_N - 1);
   localparam logic [CNT_W-1:0]  LIM_W  = CNT_W'(LAT_W - 1);
   localparam logic [LEFT_W-1:0] STEP_N = LEFT_W'(WORDS_N);
   localparam logic [LEFT_W-1:0] STEP_W = LEFT_W'(WORDS_W);

   if (LAT_N < WORDS_N + 1 || LAT_W < WORDS_W + 1) begin : g_bad_lat
      $error("kd_expand: cycle budget shorter than the schedule");
   end

   logic [WORD_W-1:0] win [NK_MAX];
   logic              busy;
   logic              wide_q;
   logic [CNT_W-1:0]  cyc;
   logic [LEFT_W-1:0] left;
   logic [2:0]        pos;
   logic [7:0]        rcon;

   logic [2:0]        last;
   logic [WORD_W-1:0] prev_w;
   logic [WORD_W-1:0] sub_w;
   logic [WORD_W-1:0] mix_w;
   logic [WORD_W-1:0] new_w;

   assign last   = wide_q ? 3'd7 : 3'd3;
   assign prev_w = win[last];

   kd_subword #(.LANES(4)) u_sub (
      .word_i (prev_w),
      .word_o (sub_w)
   );

   always_comb begin
      if (pos == 3'd0)
         mix_w = {sub_w[23:0], sub_w[31:24]} ^ {rcon, 24'h000000};
      else if (wide_q && pos == 3'd4)
         mix_w = sub_w;
      else
         mix_w = prev_w;
      new_w = win[0] ^ mix_w;
   end

   assign done_o = busy && (cyc == (wide_q ? LIM_W : LIM_N));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         wide_q <= 1'b0;
         cyc    <= '0;
         left   <= '0;
         pos    <= '0;
         rcon   <= 8'h01;
         for (int i = 0; i < NK_MAX; i++) win[i] <= '0;
      end else if (start_i) begin
         busy   <= 1'b1;
         wide_q <= wide_i;
         cyc    <= '0;
         left   <= wide_i ? STEP_W : STEP_N;
         pos    <= '0;
         rcon   <= 8'h01;
         for (int i = 0; i < 4; i++)
            win[i] <= wide_i ? key_i[32*(7-i) +: 32] : key_i[32*(3-i) +: 32];
         for (int i = 4; i < NK_MAX; i++)
            win[i] <= wide_i ? key_i[32*(7-i) +: 32] : '0;
      end else if (busy) begin
         cyc <= cyc + 1'b1;
         if (done_o) busy <= 1'b0;
         if (left != '0) begin
            left <= left - 1'b1;
            pos  <= (pos == last) ? 3'd0 : pos + 1'b1;
            if (pos == 3'd0) rcon <= gf_xtime(rcon);
            for (int i = 0; i < NK_MAX - 1; i++)
               if (i < int'(last)) win[i] <= win[i+1];
            win[last] <= new_w;
         end
      end
   end

   for (genvar j = 0; j < NK_MAX; j++) begin : g_out
      if (j < 4) begin : g_low
         assign key_o[32*j +: 32] = wide_q ? win[7-j] : win[3-j];
      end else begin : g_high
         assign key_o[32*j +: 32] = wide_q ? win[7-j] : '0;
      end
   end

   // R2
   steps_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (left == '0));

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy && !done_o));

   // R3
   budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cyc <= LIM_W || cyc <= LIM_N));

endmodule

// File: rtl/kd_regbank.sv
module kd_regbank #(
   parameter int ADDR_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [31:0]                 wdata,
   output logic [31:0]                 rdata,
   output logic                        start_o,
   output logic                        wide_o,
   output logic [kd_pkg::KEY_BITS-1:0] key_o,
   input  logic                        done_i,
   input  logic [kd_pkg::KEY_BITS-1:0] dkey_i
);
   import kd_pkg::*;

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_IV   = ADDR_W'(2 + NK_MAX);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("kd_regbank: ADDR_W too small for the register map");
   end

   ctrl_t             ctrl;
   logic              flag;
   logic [31:0]       key [NK_MAX];
   logic [31:0]       iv  [IV_WORDS];

   logic [ADDR_W-1:0] koff;
   logic [ADDR_W-1:0] ioff;
   logic              is_key;
   logic              is_iv;
   logic              preparing;
   logic [32*IV_WORDS-1:0] iv_flat;

   assign koff      = addr - A_KEY;
   assign ioff      = addr - A_IV;
   assign is_key    = koff < ADDR_W'(NK_MAX);
   assign is_iv     = ioff < ADDR_W'(IV_WORDS);
   assign preparing = ctrl.run && (ctrl.mode == OP_PREPARE);

   assign start_o = wr_en && (addr == A_CTRL) && !preparing && wdata[0]
                    && (wdata[2:1] == OP_PREPARE);
   assign wide_o  = wdata[3];

   for (genvar j = 0; j < NK_MAX; j++) begin : g_kflat
      assign key_o[32*j +: 32] = key[j];
   end
   for (genvar j = 0; j < IV_WORDS; j++) begin : g_iflat
      assign iv_flat[32*j +: 32] = iv[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         flag <= 1'b0;
         for (int j = 0; j < NK_MAX; j++) key[j] <= '0;
         for (int j = 0; j < IV_WORDS; j++) iv[j] <= '0;
      end else if (done_i) begin
         flag     <= 1'b1;
         ctrl.run <= 1'b0;
         for (int j = 0; j < 4; j++) key[j] <= dkey_i[32*j +: 32];
         for (int j = 4; j < NK_MAX; j++)
            if (ctrl.wide) key[j] <= dkey_i[32*j +: 32];
      end else if (wr_en) begin
         if (addr == A_CTRL && !preparing) ctrl <= ctrl_t'(wdata[6:0]);
         if (addr == A_CLR && wdata[0]) flag <= 1'b0;
         if (is_key && !ctrl.run) key[koff[2:0]] <= wdata;
         if (is_iv && ctrl.mode != OP_PREPARE) iv[ioff[1:0]] <= wdata;
      end
   end

   always_comb begin
      if (addr == A_CTRL)
         rdata = {23'd0, flag, 1'b0, ctrl};
      else if (is_key)
         rdata = key[koff[2:0]];
      else if (is_iv)
         rdata = iv[ioff[1:0]];
      else
         rdata = '0;
   end

   // R2
   flag_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $fell(ctrl.run));

   // R6
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (preparing && !done_i) |=> $stable(key_o));

   // R8
   iv_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_iv && ctrl.mode == OP_PREPARE) |=> $stable(iv_flat));

   // R10
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(wr_en && addr == A_CLR && wdata[0]));

   // R11
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (preparing && !done_i) |=> $stable(ctrl));

   // R9
   flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(ctrl.mode) == OP_PREPARE));

endmodule

// File: rtl/aes_dec_key_prep.sv
module aes_dec_key_prep #(
   parameter int ADDR_W  = 4,
   parameter int LAT_128 = 59,
   parameter int LAT_256 = 82
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   import kd_pkg::*;

   if (LAT_256 <= LAT_128) begin : g_bad_order
      $error("aes_dec_key_prep: wide budget must exceed narrow budget");
   end

   logic                start;
   logic                wide;
   logic                done;
   logic [KEY_BITS-1:0] key_cur;
   logic [KEY_BITS-1:0] key_new;

   kd_regbank #(.ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .start_o (start),
      .wide_o  (wide),
      .key_o   (key_cur),
      .done_i  (done),
      .dkey_i  (key_new)
   );

   kd_expand #(.LAT_N(LAT_128), .LAT_W(LAT_256)) u_expand (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .wide_i  (wide),
      .key_i   (key_cur),
      .done_o  (done),
      .key_o   (key_new)
   );

endmodule

// File: tb/aes_dec_key_prep_test.sv
module aes_dec_key_prep_test;
   localparam int CLK_PERIOD = 10;
   localparam int A_CTRL = 0, A_CLR = 1, A_KEY = 2, A_IV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   int ticks = 0;
   logic [7:0]  sb [256];
   logic [31:0] mkey [8];

   aes_dec_key_prep uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      ticks++;
      if (ticks > 100000) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 4'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic check_keys(input string req);
      logic [31:0] v;
      for (int j = 0; j < 8; j++) begin
         rd(A_KEY + j, v);
         chk(req, v, mkey[j]);
      end
      reg_addr = '0;
   endtask

   function automatic logic [31:0] sub32(input logic [31:0] x);
      return {sb[x[31:24]], sb[x[23:16]], sb[x[15:8]], sb[x[7:0]]};
   endfunction

   function automatic logic [7:0] dbl(input logic [7:0] a);
      return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
   endfunction

   task automatic model_derive(input bit wide);
      logic [31:0] w [60];
      logic [31:0] t;
      logic [7:0]  rc;
      int nk, total;
      nk = wide ? 8 : 4;
      total = 4 * (nk + 7);
      for (int i = 0; i < nk; i++) w[i] = mkey[nk-1-i];
      rc = 8'h01;
      for (int i = nk; i < total; i++) begin
         t = w[i-1];
         if (i % nk == 0) begin
            t = sub32({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            rc = dbl(rc);
         end else if (nk == 8 && i % 8 == 4) begin
            t = sub32(t);
         end
         w[i] = w[i-nk] ^ t;
      end
      for (int j = 0; j < nk; j++) mkey[nk-1-j] = w[total-nk+j];
   endtask

   // per-clock comparison of the control word during a preparation
   task automatic run_watch(input int lat, input logic [31:0] cv, input bit inj, input string req);
      logic [31:0] exp, v;
      for (int k = 1; k <= lat + 3; k++) begin
         @(negedge clk);
         reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
         #1;
         exp = (k < lat) ? cv : ((cv & 32'hffff_fffe) | 32'h100);
         chk(req, reg_rdata, exp);
         if (inj && k == 3) begin         // R6 key write while running
            reg_we = 1'b1; reg_addr = 4'(A_KEY); reg_wdata = 32'hdead_beef;
         end else if (inj && k == 6) begin // R11 control write while running
            reg_we = 1'b1; reg_addr = 4'(A_CTRL); reg_wdata = 32'h0;
         end else if (inj && k == 9) begin // R6 old key still readable
            rd(A_KEY + 3, v);
            chk("R6", v, mkey[3]);
         end
      end
   endtask

   initial begin : main
      logic [7:0] p, q, x;
      logic [31:0] v;
      // S-box from the multiplicative generator 3
      p = 8'h01; q = 8'h01;
      do begin
         p = p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1b : 8'h00);
         q = q ^ (q << 1);
         q = q ^ (q << 2);
         q = q ^ (q << 4);
         if ((q & 8'h80) != 0) q = q ^ 8'h09;
         x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
         sb[p] = x ^ 8'h63;
      end while (p != 8'h01);
      sb[0] = 8'h63;
      for (int j = 0; j < 8; j++) mkey[j] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1
      rd(A_CTRL, v); chk("R1", v, 32'h0);
      rd(A_IV, v);   chk("R1", v, 32'h0);
      check_keys("R1");

      for (int j = 4; j < 8; j++) begin
         wr(A_KEY + j, 32'ha5a5_0000 + j); mkey[j] = 32'ha5a5_0000 + j;
      end
      wr(A_KEY + 3, 32'h2b7e1516); mkey[3] = 32'h2b7e1516;
      wr(A_KEY + 2, 32'h28aed2a6); mkey[2] = 32'h28aed2a6;
      wr(A_KEY + 1, 32'habf71588); mkey[1] = 32'habf71588;
      wr(A_KEY + 0, 32'h09cf4f3c); mkey[0] = 32'h09cf4f3c;
      wr(A_CTRL, 32'h3);
      run_watch(59, 32'h3, 1'b0, "R2");
      model_derive(1'b0);
      check_keys("R4");
      rd(A_KEY + 3, v); chk("R4", v, 32'hd014f9a8);
      rd(A_KEY + 0, v); chk("R4", v, 32'hb6630ca6);
      rd(A_KEY + 7, v); chk("R4", v, 32'ha5a5_0007);

      // R10 clear behaviour
      wr(A_CLR, 32'h0); rd(A_CTRL, v); chk("R10", v, 32'h102);
      wr(A_CLR, 32'h1); rd(A_CTRL, v); chk("R10", v, 32'h002);

      // 256-bit key with writes injected mid-run
      begin
         logic [31:0] k256 [8];
         k256 = '{32'h0914dff4, 32'h2d9810a3, 32'h3b6108d7, 32'h1f352c07,
                  32'h857d7781, 32'h2b73aef0, 32'h15ca71be, 32'h603deb10};
         for (int j = 7; j >= 0; j--) begin
            wr(A_KEY + j, k256[j]); mkey[j] = k256[j];
         end
      end
      wr(A_CTRL, 32'hb);
      run_watch(82, 32'hb, 1'b1, "R3");
      model_derive(1'b1);
      check_keys("R5");
      rd(A_KEY + 3, v); chk("R5", v, 32'hfe4890d1);
      rd(A_KEY + 0, v); chk("R5", v, 32'h706c631e);
      wr(A_CLR, 32'h1);

      // R7 chaining field has no effect
      wr(A_KEY + 3, 32'h2b7e1516); mkey[3] = 32'h2b7e1516;
      wr(A_KEY + 2, 32'h28aed2a6); mkey[2] = 32'h28aed2a6;
      wr(A_KEY + 1, 32'habf71588); mkey[1] = 32'habf71588;
      wr(A_KEY + 0, 32'h09cf4f3c); mkey[0] = 32'h09cf4f3c;
      wr(A_CTRL, 32'h53);
      run_watch(59, 32'h53, 1'b0, "R7");
      model_derive(1'b0);
      rd(A_KEY + 3, v); chk("R7", v, 32'hd014f9a8);
      rd(A_KEY + 1, v); chk("R7", v, 32'he13f0cc8);

      // R10 restart from the prepared key
      wr(A_CLR, 32'h1);
      wr(A_CTRL, 32'h3);
      run_watch(59, 32'h3, 1'b0, "R10");
      model_derive(1'b0);
      check_keys("R10");
      wr(A_CLR, 32'h1);

      // R8 vector writes
      wr(A_CTRL, 32'h2);
      wr(A_IV, 32'h0000_1234); rd(A_IV, v); chk("R8", v, 32'h0);
      wr(A_CTRL, 32'h4);
      wr(A_IV, 32'hcafe_1234); rd(A_IV, v); chk("R8", v, 32'hcafe_1234);

      // R9 decrypt-only mode
      wr(A_CTRL, 32'h5);
      repeat (100) @(negedge clk);
      rd(A_CTRL, v); chk("R9", v, 32'h5);
      check_keys("R9");
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v); chk("R9", v, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule